// File: doc/BRIEF.md
# SPI Slave Register Interface

This block is the serial front end of a bank of 48 eight-bit configuration registers. A host controller talks to it over a four-wire SPI link in mode 0. Each transaction opens with a header byte that holds a read/write flag, a burst flag and a six-bit register address. Data bytes follow the header. The link is full duplex, so the block always returns a byte while it receives one. During every header byte it returns a status byte. It also returns a status byte during each byte written to a register. During a read, the bytes after the header carry register contents instead.

The status byte gives the host three things: an active-low ready flag, a three-bit code for the radio's main state, and the number of free transmit FIFO bytes, capped at 15. All three come from input ports. The block samples them at the start of each byte that carries status. With burst set, an internal address pointer starts at the header address and advances after every data byte. This lets the host reach a run of consecutive registers without sending another header.

All SPI pins are brought into the system clock domain through synchronizer chains. SCLK must therefore run well below the system clock; a half period of at least six system clocks leaves enough margin.

Top module: `spi_reg_if`

## Requirements
- R1: While each header byte is received, a status byte is shifted out on `miso`, most significant bit first. Its bit 7 is on `miso` before the first rising SCLK edge after `cs_n` falls.
- R2: Status bit 7 carries `ready_n`, bits 6:4 carry the main-state code, and bits 3:0 carry the free-byte field.
- R3: State codes 000, 010, 011, 100, 101 and 111 are reported as given. The unused codes 001 and 110 are reported as 000.
- R4: The free-byte field equals `tx_free` when `tx_free` is below 15, and reads 15 when `tx_free` is 15 or more.
- R5: Status inputs are sampled when a status-carrying byte begins and are held unchanged while that byte is shifted out, even if the inputs change.
- R6: On a write access, every data byte returns a freshly sampled status byte, and the received byte is stored at the current address.
- R7: On a read access, the bytes after the header return the addressed register contents, MSB first, and no status.
- R8: Header bit 7 set means read and clear means write; bit 6 is the burst flag; bits 5:0 are the address. `mosi` is sampled on rising SCLK edges and `miso` changes only after falling edges (mode 0).
- R9: With burst set, the address pointer advances by one after each data byte, wrapping from 0x3F to 0x00.
- R10: Without burst, exactly one data byte is accessed, and the next byte in the same selection is treated as a new header.
- R11: Writes to addresses 0x30 to 0x3F change no register, and reads from them return 0x00.
- R12: Raising `cs_n` ends the transaction and discards a partial byte; the next selection starts with a header. `miso` is low while deselected and after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host (registered) |
| ready_n | input | 1 | Active-low ready flag placed in status bit 7 |
| main_state | input | 3 | Main state code placed in status bits 6:4 |
| tx_free | input | FREE_W | Free transmit FIFO byte count, saturated into status bits 3:0 |

## Verification
The bench goes after the status byte's source and timing, the framing of each access, and the edges of the address space.

It changes the status inputs halfway through a header byte. A design that sampled them late would return a mixed byte, and one that sampled only once per transaction would return stale status on the next write byte.

It runs bursts across 0x2F and across 0x3F, and mixes non-burst write and read accesses inside one selection. An address counter that fails to wrap, or that aliases high addresses onto real registers, corrupts the readback. So does a framing error that treats a second header as data.

It also sweeps every state code against free counts around 15, and aborts a write in mid-byte. A design that leaks unused state codes, wraps the free field instead of saturating it, or commits a partial byte would show it at `miso`.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  // Header address width is fixed by the header byte layout.
  localparam int HDR_AW = 6;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              rd;
    logic              burst;
    logic [HDR_AW-1:0] addr;
  } hdr_t;

  typedef enum logic [2:0] {
    MS_IDLE      = 3'd0,
    MS_SPARE_A   = 3'd1,
    MS_SEND      = 3'd2,
    MS_SEND_RDY  = 3'd3,
    MS_CALIB     = 3'd4,
    MS_SETTLE    = 3'd5,
    MS_SPARE_B   = 3'd6,
    MS_UNDERRUN  = 3'd7
  } mstate_t;

  typedef enum logic {
    PH_HDR  = 1'b0,
    PH_DATA = 1'b1
  } phase_t;

  // Unused codes are folded onto idle before they reach the host.
  function automatic logic [2:0] fold_state(input logic [2:0] raw);
    logic [2:0] res;
    case (mstate_t'(raw))
      MS_SPARE_A, MS_SPARE_B: res = MS_IDLE;
      default:                res = raw;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic cs_start,
  output logic mosi_s
);

  // Pin order inside the vector: {mosi, cs_n, sclk}
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] IDLE_LVL = NPIN'(3'b010);

  logic [NPIN-1:0] pins_in;
  logic [NPIN-1:0] pins_s;
  logic            sclk_prev;
  logic            act_prev;

  assign pins_in = {mosi, cs_n, sclk};

  for (genvar g = 0; g < NPIN; g++) begin : g_chain
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{IDLE_LVL[g]}};
      else     chain <= {chain[STAGES-2:0], pins_in[g]};
    end
    assign pins_s[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      act_prev  <= 1'b0;
    end else begin
      sclk_prev <= pins_s[0];
      act_prev  <= ~pins_s[1];
    end
  end

  assign sclk_rise = pins_s[0] & ~sclk_prev;
  assign sclk_fall = ~pins_s[0] & sclk_prev;
  assign cs_act    = ~pins_s[1];
  assign cs_start  = ~pins_s[1] & ~act_prev;
  assign mosi_s    = pins_s[2];

endmodule

// File: rtl/spi_status_pack.sv
module spi_status_pack
  import spi_reg_pkg::*;
#(
  parameter int FREE_W = 7
) (
  input  logic              ready_n,
  input  logic [2:0]        main_state,
  input  logic [FREE_W-1:0] tx_free,
  output logic [BYTE_W-1:0] status
);

  localparam logic [FREE_W-1:0] FREE_CAP = FREE_W'(15);

  logic [3:0] free_field;

  always_comb begin
    if (tx_free >= FREE_CAP) free_field = 4'hF;
    else                     free_field = tx_free[3:0];
  end

  assign status = {ready_n, fold_state(main_state), free_field};

endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
  import spi_reg_pkg::*;
#(
  parameter int DEPTH = 48
) (
  input  logic              clk,
  input  logic              we,
  input  logic [HDR_AW-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [HDR_AW-1:0] raddr,
  output logic [BYTE_W-1:0] rdata
);

  localparam logic [HDR_AW-1:0] TOP_ADDR = HDR_AW'(DEPTH - 1);

  logic [BYTE_W-1:0] mem [DEPTH];

  // Plain write port and registered read port so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we && (waddr <= TOP_ADDR)) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (raddr <= TOP_ADDR) rdata <= mem[raddr];
    else                   rdata <= '0;
  end

endmodule

// File: rtl/spi_reg_if.sv
module spi_reg_if
  import spi_reg_pkg::*;
#(
  parameter int DEPTH       = 48,
  parameter int FREE_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              ready_n,
  input  logic [2:0]        main_state,
  input  logic [FREE_W-1:0] tx_free
);

  localparam int               CNT_W    = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [HDR_AW-1:0] ADDR_ONE = HDR_AW'(1);

  logic              sclk_rise;
  logic              sclk_fall;
  logic              cs_act;
  logic              cs_start;
  logic              mosi_s;
  logic [BYTE_W-1:0] status;
  logic [BYTE_W-1:0] rdata;

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;
  logic [BYTE_W-1:0] rx_byte;
  hdr_t              hdr_in;
  phase_t            phase;
  logic              rd_flag;
  logic              burst_flag;
  logic [HDR_AW-1:0] ptr;
  logic              we;
  logic [HDR_AW-1:0] waddr;
  logic [BYTE_W-1:0] wdata;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_act    (cs_act),
    .cs_start  (cs_start),
    .mosi_s    (mosi_s)
  );

  spi_status_pack #(.FREE_W(FREE_W)) u_stat (
    .ready_n    (ready_n),
    .main_state (main_state),
    .tx_free    (tx_free),
    .status     (status)
  );

  spi_cfg_bank #(.DEPTH(DEPTH)) u_bank (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (ptr),
    .rdata (rdata)
  );

  assign rx_byte = {rx_sr, mosi_s};
  assign hdr_in  = hdr_t'(rx_byte);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      phase      <= PH_HDR;
      rd_flag    <= 1'b0;
      burst_flag <= 1'b0;
      ptr        <= '0;
      we         <= 1'b0;
      waddr      <= '0;
      wdata      <= '0;
    end else begin
      we <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
        phase   <= PH_HDR;
        tx_sr   <= '0;
      end else if (cs_start) begin
        bit_cnt <= '0;
        phase   <= PH_HDR;
        tx_sr   <= status;
      end else if (sclk_rise) begin
        rx_sr   <= rx_byte[BYTE_W-2:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          if (phase == PH_HDR) begin
            rd_flag    <= hdr_in.rd;
            burst_flag <= hdr_in.burst;
            ptr        <= hdr_in.addr;
            phase      <= PH_DATA;
          end else begin
            if (!rd_flag) begin
              we    <= 1'b1;
              waddr <= ptr;
              wdata <= rx_byte;
            end
            if (burst_flag) ptr   <= ptr + ADDR_ONE;
            else            phase <= PH_HDR;
          end
        end
      end else if (sclk_fall) begin
        if (bit_cnt == '0) begin
          if (phase == PH_DATA && rd_flag) tx_sr <= rdata;
          else                             tx_sr <= status;
        end else begin
          tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso = tx_sr[BYTE_W-1];

endmodule

// File: rtl/spi_reg_if_chk.sv
module spi_reg_if_chk
  import spi_reg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ready_n,
  input logic              miso,
  input logic              cs_act,
  input logic              cs_start,
  input logic              sclk_rise,
  input logic              sclk_fall,
  input logic [2:0]        bit_cnt,
  input phase_t            phase,
  input logic              burst_flag,
  input logic [HDR_AW-1:0] ptr
);

  // R1, R2: first status bit at selection is the ready flag of that cycle
  p_hdr_ready_r2: assert property (@(posedge clk) disable iff (rst)
    cs_start |=> (miso == $past(ready_n)));

  // R5, R8: miso moves only on a falling edge or a new selection
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !cs_start && !sclk_fall) |=> $stable(miso));

  // R12: deselection clears output and framing
  p_deselect_r12: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (!miso && bit_cnt == 3'd0 && phase == PH_HDR));

  // R8: each rising edge inside a selection counts one bit
  p_bitcnt_r8: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !cs_start && sclk_rise) |=> (bit_cnt == 3'($past(bit_cnt) + 3'd1)));

  // R9: burst data byte completion advances the pointer
  p_burst_inc_r9: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !cs_start && sclk_rise && bit_cnt == 3'd7 && phase == PH_DATA && burst_flag)
      |=> (ptr == 6'($past(ptr) + 6'd1)));

  // R10: single access returns to header framing
  p_single_r10: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !cs_start && sclk_rise && bit_cnt == 3'd7 && phase == PH_DATA && !burst_flag)
      |=> (phase == PH_HDR));

endmodule

bind spi_reg_if spi_reg_if_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ready_n    (ready_n),
  .miso       (miso),
  .cs_act     (cs_act),
  .cs_start   (cs_start),
  .sclk_rise  (sclk_rise),
  .sclk_fall  (sclk_fall),
  .bit_cnt    (bit_cnt),
  .phase      (phase),
  .burst_flag (burst_flag),
  .ptr        (ptr)
);

// File: tb/sim_spi_reg_if.sv
`timescale 1ns/1ps
module sim_spi_reg_if;

  localparam int HALF  = 64;
  localparam int NREG  = 48;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic       miso;
  logic       rdy = 1'b0;
  logic [2:0] st = 3'd0;
  logic [6:0] free = 7'd0;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NREG];
  logic [7:0] wbuf  [64];

  always #4 clk = ~clk;

  spi_reg_if u0 (
    .clk        (clk),
    .rst        (rst),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .mosi       (mosi),
    .miso       (miso),
    .ready_n    (rdy),
    .main_state (st),
    .tx_free    (free)
  );

  function automatic logic [7:0] exp_status(input logic r, input logic [2:0] s, input logic [6:0] f);
    logic [2:0] s2;
    logic [3:0] f2;
    s2 = (s == 3'd1 || s == 3'd6) ? 3'd0 : s;
    f2 = (f >= 7'd15) ? 4'd15 : f[3:0];
    return {r, s2, f2};
  endfunction

  function automatic logic [7:0] exp_read(input int idx);
    return (idx < NREG) ? model[idx] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = tx[i];
      #(HALF);
      rx = {rx[6:0], miso};
      sclk = 1'b1;
      #(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic cs_hi();
    #(HALF);
    cs_n = 1'b1;
    #(2*HALF);
  endtask

  task automatic do_write(input logic [5:0] a, input logic burst, input int n);
    logic [7:0] rx;
    int idx;
    cs_lo();
    spi_byte({1'b0, burst, a}, rx);
    chk("R1 status during write header", rx, exp_status(rdy, st, free));
    for (int i = 0; i < n; i++) begin
      spi_byte(wbuf[i], rx);
      chk("R6 status during write data", rx, exp_status(rdy, st, free));
      idx = (int'(a) + i) % 64;
      if (idx < NREG) model[idx] = wbuf[i];
    end
    cs_hi();
  endtask

  task automatic do_read(input logic [5:0] a, input logic burst, input int n, input string tag);
    logic [7:0] rx;
    cs_lo();
    spi_byte({1'b1, burst, a}, rx);
    chk("R1 status during read header", rx, exp_status(rdy, st, free));
    for (int i = 0; i < n; i++) begin
      spi_byte(8'h00, rx);
      chk(tag, rx, exp_read((int'(a) + i) % 64));
    end
    cs_hi();
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    logic [7:0] e1;
    logic [7:0] old7;
    logic [6:0] frees [6];
    void'($urandom(32'd5150));
    frees[0] = 7'd0;  frees[1] = 7'd9;  frees[2] = 7'd14;
    frees[3] = 7'd15; frees[4] = 7'd16; frees[5] = 7'd127;

    #(161);
    rst = 1'b0;
    #(16);
    chk("R12 miso low after reset", {7'd0, miso}, 8'h00);
    #(2*HALF - 16);

    // R8 R9: fill every register with one burst, read it back with another
    for (int i = 0; i < NREG; i++) wbuf[i] = 8'($urandom);
    st = 3'd2; free = 7'd3;
    do_write(6'h00, 1'b1, NREG);
    do_read(6'h00, 1'b1, NREG, "R7 R8 R9 burst readback");

    // R2 R3 R4: all state codes against free counts around the cap
    for (int s = 0; s < 8; s++) begin
      for (int f = 0; f < 6; f++) begin
        st = 3'(s); free = frees[f]; rdy = 1'b0;
        cs_lo();
        spi_byte({1'b1, 1'b0, 6'd1}, rx);
        chk("R2 R3 R4 status fields", rx, exp_status(rdy, st, free));
        cs_hi();
      end
    end
    rdy = 1'b1; st = 3'd5; free = 7'd4;
    cs_lo();
    spi_byte({1'b1, 1'b0, 6'd1}, rx);
    chk("R2 ready flag in bit 7", rx, exp_status(rdy, st, free));
    cs_hi();
    rdy = 1'b0;

    // R5 R6: inputs change mid-header; header keeps old, data byte takes new
    st = 3'd2; free = 7'd5;
    e1 = exp_status(rdy, st, free);
    cs_lo();
    for (int i = 7; i >= 0; i--) begin
      mosi = (i < 6) ? (6'd10 >> i) & 1'b1 : 1'b0;
      #(HALF);
      rx = {rx[6:0], miso};
      sclk = 1'b1;
      #(HALF);
      sclk = 1'b0;
      if (i == 4) begin st = 3'd4; free = 7'd20; end
    end
    chk("R5 status held during header", rx, e1);
    spi_byte(8'h5A, rx);
    chk("R6 fresh status during write data", rx, exp_status(rdy, st, free));
    model[10] = 8'h5A;
    cs_hi();
    do_read(6'd10, 1'b0, 1, "R6 written byte stored");

    // R11: burst write across 0x2F, then read across it
    for (int i = 0; i < 6; i++) wbuf[i] = 8'($urandom);
    do_write(6'h2C, 1'b1, 6);
    do_read(6'h2E, 1'b1, 4, "R11 reads at and past 0x2F");
    do_read(6'h3A, 1'b0, 1, "R11 high address reads zero");

    // R9: burst wrap from 0x3F to 0x00
    for (int i = 0; i < 3; i++) wbuf[i] = 8'($urandom);
    do_write(6'h3E, 1'b1, 3);
    do_read(6'h3F, 1'b1, 3, "R9 pointer wraps to 0x00");

    // R10: single accesses chained inside one selection
    cs_lo();
    spi_byte({1'b0, 1'b0, 6'd5}, rx);
    chk("R10 first header status", rx, exp_status(rdy, st, free));
    spi_byte(8'hC3, rx);
    model[5] = 8'hC3;
    spi_byte({1'b1, 1'b0, 6'd5}, rx);
    chk("R10 second header returns status", rx, exp_status(rdy, st, free));
    spi_byte(8'h00, rx);
    chk("R10 read after new header", rx, 8'hC3);
    spi_byte({1'b0, 1'b0, 6'd6}, rx);
    chk("R10 third header returns status", rx, exp_status(rdy, st, free));
    spi_byte(8'h77, rx);
    model[6] = 8'h77;
    cs_hi();
    do_read(6'd5, 1'b1, 2, "R10 chained writes stored");

    // R12: abort a write mid-byte, next selection is a clean header
    old7 = model[7];
    cs_lo();
    spi_byte({1'b0, 1'b0, 6'd7}, rx);
    spi_bits(8'hFF, 4, rx);
    cs_hi();
    chk("R12 miso low while deselected", {7'd0, miso}, 8'h00);
    do_read(6'd7, 1'b0, 1, "R12 aborted byte not written");
    chk("R12 register kept old value", model[7], old7);

    // Random mix
    for (int k = 0; k < 40; k++) begin
      logic [5:0] a;
      logic       b;
      int         n;
      rdy  = 1'($urandom_range(0, 1));
      st   = 3'($urandom_range(0, 7));
      free = 7'($urandom_range(0, 127));
      a    = 6'($urandom_range(0, 58));
      b    = 1'($urandom_range(0, 1));
      n    = b ? $urandom_range(1, 5) : 1;
      if ($urandom_range(0, 1) == 1) begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        do_write(a, b, n);
      end else begin
        do_read(a, b, n, "R7 R9 R11 random read");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule